// File: doc/BRIEF.md
# Programmable Baud Rate Divider

This block divides a reference clock by a 16-bit divisor to make the 16x sampling strobe for a serial port. The divisor is held in two byte-wide latches. Software writes each latch through a small write port with an enable, a byte select and a data byte. A write to either byte takes effect in the next cycle and restarts the division period, so no leftover count from the old divisor remains.

The block produces two outputs. `div_out` is the divided waveform. Its shape depends on the divisor. `tick` is a one-cycle enable that marks the first high cycle of each output period. Transmit and receive logic use `tick` in place of a second clock.

Divisors 0, 1 and 2 have their own shapes. A divisor of 0 runs as divide-by-3. A divisor of 1 passes the inverted reference clock. A divisor of 2 gives a 50% square wave.

Top module: `baud_divider`

## Requirements
- R1: A synchronous active-low reset clears both latches to 0. While reset is held, `div_out` and `tick` are 0. The first output period after reset runs as divide-by-3.
- R2: A write with `wr_sel`=0 loads `wr_data` into divisor bits 7:0. A write with `wr_sel`=1 loads it into bits 15:8. The other byte is kept.
- R3: A write to either latch restarts the period. In the cycle after the write edge, the output is in the first cycle of a fresh period under the new divisor.
- R4: For a divisor N of 3 or more, each period lasts N cycles: `div_out` is low for the first 2 cycles and high for the other N-2.
- R5: A divisor of 0 behaves exactly as a divisor of 3: low for 2 cycles, high for 1.
- R6: With a divisor of 1, `div_out` is the inverse of `clk`, and `tick` is high in every cycle.
- R7: With a divisor of 2, `div_out` is low for one cycle and high for the next.
- R8: For any divisor other than 1, `tick` is high for exactly one cycle per period, and that cycle is the first one in which `div_out` is high.
- R9: While `wr_en` is low, the values on `wr_sel` and `wr_data` change neither the divisor nor the period phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock to be divided |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Latch write strobe, one cycle per byte |
| wr_sel | input | 1 | Byte select: 0 = low byte, 1 = high byte |
| wr_data | input | 8 | Byte to be written |
| div_out | output | 1 | Divided output waveform |
| tick | output | 1 | One-cycle pulse on the first high cycle of each period |

## Verification
The assertions assume that reset and the write port are driven synchronously to `clk`. They assume that `div_out` is only meaningful at a clock edge when the divisor is not 1, because in that mode it follows the clock itself. They also assume that the only way the divisor changes is through a write strobe. The checker therefore keeps its own copy of the divisor, built from the write port, and clears its period measurement on every write. The bench drives all inputs half a cycle away from the sampling edge. It keeps divisors small, with occasional high-byte values, so that many full periods fit into the run. It checks the inverted-clock mode on both clock phases.

// File: rtl/baud_div_pkg.sv
// Package: shared widths and helpers for the baud rate divider.
// Assumes the divisor width is a whole number of bytes.
package baud_div_pkg;

    localparam int unsigned DEF_DIV_W  = 16;
    localparam int unsigned DEF_BYTE_W = 8;

    // Encoding of the operating shape chosen by the effective divisor.
    typedef enum logic [1:0] {
        SHAPE_INV_CLK = 2'd0,  // divisor 1: inverted reference clock
        SHAPE_HALF    = 2'd1,  // divisor 2: 50% square wave
        SHAPE_LONG    = 2'd2   // divisor 3 or more (0 mapped to 3)
    } shape_e;

    // Map a raw divisor to the period length actually used.
    function automatic logic [DEF_DIV_W-1:0] eff_period(input logic [DEF_DIV_W-1:0] raw);
        eff_period = (raw == '0) ? DEF_DIV_W'(3) : raw;
    endfunction

    // Classify an effective period into its output shape.
    function automatic shape_e shape_of(input logic [DEF_DIV_W-1:0] eff);
        if (eff == DEF_DIV_W'(1))      shape_of = SHAPE_INV_CLK;
        else if (eff == DEF_DIV_W'(2)) shape_of = SHAPE_HALF;
        else                           shape_of = SHAPE_LONG;
    endfunction

endpackage

// File: rtl/baud_div_latch.sv
// Divisor latch bank: one byte register per slice of the divisor.
// Presents the stored divisor, the value it will hold after the current
// write, and a load strobe. Assumes writes are synchronous to clk.
module baud_div_latch #(
    parameter int unsigned DIV_W  = 16,
    parameter int unsigned BYTE_W = 8,
    localparam int unsigned NUM_BYTES = DIV_W / BYTE_W,
    localparam int unsigned SEL_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [DIV_W-1:0]  div_q,
    output logic [DIV_W-1:0]  div_next,
    output logic              load
);

    logic [NUM_BYTES-1:0] hit;

    for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
        logic [BYTE_W-1:0] byte_q;

        // Decode whether this byte slice is the write target.
        assign hit[b] = wr_en && (wr_sel == SEL_W'(b));

        // Hold one divisor byte; clear on reset, replace on a hit.
        always_ff @(posedge clk) begin
            if (!rst_n)      byte_q <= '0;
            else if (hit[b]) byte_q <= wr_data;
        end

        // Expose the stored byte and the value after this cycle's write.
        assign div_q[b*BYTE_W +: BYTE_W]    = byte_q;
        assign div_next[b*BYTE_W +: BYTE_W] = hit[b] ? wr_data : byte_q;
    end

    // Any accepted write restarts the counter.
    assign load = |hit;

endmodule

// File: rtl/baud_div_counter.sv
// Period counter: counts down from the effective divisor to 1 and
// reloads. A load strobe forces an immediate reload with a new period.
// Assumes eff_cur and eff_new are never zero.
module baud_div_counter #(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DIV_W-1:0] eff_new,
    input  logic [DIV_W-1:0] eff_cur,
    output logic [DIV_W-1:0] cnt
);

    localparam logic [DIV_W-1:0] RESET_PERIOD = DIV_W'(3);

    // Count down, reload at the end of a period or on a latch write.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt <= RESET_PERIOD;
        else if (load)               cnt <= eff_new;
        else if (cnt <= DIV_W'(1))   cnt <= eff_cur;
        else                         cnt <= cnt - DIV_W'(1);
    end

endmodule

// File: rtl/baud_div_shaper.sv
// Output shaper: turns the counter state into the divided waveform and
// the one-cycle tick. Divisor 1 passes the inverted clock through.
// Assumes cnt lies in 1..eff.
module baud_div_shaper #(
    parameter int unsigned DIV_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [DIV_W-1:0]          cnt,
    input  logic [DIV_W-1:0]          eff,
    input  baud_div_pkg::shape_e      shape,
    output logic                      div_out,
    output logic                      tick
);
    import baud_div_pkg::*;

    logic out_hi;
    logic first_hi;

    // Decide the level and the first-high cycle for the active shape.
    always_comb begin
        out_hi   = 1'b0;
        first_hi = 1'b0;
        case (shape)
            SHAPE_INV_CLK: begin
                out_hi   = ~clk;
                first_hi = 1'b1;
            end
            SHAPE_HALF: begin
                out_hi   = (cnt == DIV_W'(1));
                first_hi = (cnt == DIV_W'(1));
            end
            default: begin
                out_hi   = (cnt <= eff - DIV_W'(2));
                first_hi = (cnt == eff - DIV_W'(2));
            end
        endcase
    end

    // Hold both outputs quiet during reset.
    assign div_out = rst_n & out_hi;
    assign tick    = rst_n & first_hi;

endmodule

// File: rtl/baud_divider.sv
// Top: programmable baud rate divider. Byte-wide latch writes set a
// 16-bit divisor and restart the period; outputs the divided waveform
// and a one-cycle tick. Assumes all inputs are synchronous to clk.
module baud_divider #(
    parameter int unsigned DIV_W  = 16,
    parameter int unsigned BYTE_W = 8,
    localparam int unsigned NUM_BYTES = DIV_W / BYTE_W,
    localparam int unsigned SEL_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              div_out,
    output logic              tick
);
    import baud_div_pkg::*;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] div_next;
    logic             load;
    logic [DIV_W-1:0] eff_cur;
    logic [DIV_W-1:0] eff_new;
    logic [DIV_W-1:0] cnt;
    shape_e           shape;

    baud_div_latch #(.DIV_W(DIV_W), .BYTE_W(BYTE_W)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .div_q    (div_q),
        .div_next (div_next),
        .load     (load)
    );

    // Map raw divisors (stored and incoming) to effective periods.
    always_comb begin
        eff_cur = (div_q    == '0) ? DIV_W'(3) : div_q;
        eff_new = (div_next == '0) ? DIV_W'(3) : div_next;
        if (eff_cur == DIV_W'(1))      shape = SHAPE_INV_CLK;
        else if (eff_cur == DIV_W'(2)) shape = SHAPE_HALF;
        else                           shape = SHAPE_LONG;
    end

    baud_div_counter #(.DIV_W(DIV_W)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .eff_new (eff_new),
        .eff_cur (eff_cur),
        .cnt     (cnt)
    );

    baud_div_shaper #(.DIV_W(DIV_W)) u_shaper (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt     (cnt),
        .eff     (eff_cur),
        .shape   (shape),
        .div_out (div_out),
        .tick    (tick)
    );

endmodule

// File: rtl/baud_divider_chk.sv
// Checker for baud_divider: keeps its own divisor copy from the write
// port and measures tick spacing with a counter. Bound to the top.
module baud_divider_chk #(
    parameter int unsigned DIV_W  = 16,
    parameter int unsigned BYTE_W = 8,
    localparam int unsigned SEL_W = ((DIV_W / BYTE_W) > 1) ? $clog2(DIV_W / BYTE_W) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [SEL_W-1:0]  wr_sel,
    input logic [BYTE_W-1:0] wr_data,
    input logic              div_out,
    input logic              tick
);

    logic [DIV_W-1:0] shadow;
    logic [DIV_W-1:0] per;
    logic [DIV_W-1:0] gap;
    logic             gap_ok;

    // Shadow the divisor from the write port.
    always_ff @(posedge clk) begin
        if (!rst_n) shadow <= '0;
        else if (wr_en) shadow[wr_sel*BYTE_W +: BYTE_W] <= wr_data;
    end

    assign per = (shadow == '0) ? DIV_W'(3) : shadow;

    // Count cycles since the last tick; invalidate across writes.
    always_ff @(posedge clk) begin
        if (!rst_n || wr_en) begin
            gap    <= '0;
            gap_ok <= 1'b0;
        end else if (tick) begin
            gap    <= DIV_W'(1);
            gap_ok <= 1'b1;
        end else begin
            gap    <= gap + DIV_W'(1);
        end
    end

    AST_RESTART_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !$isunknown(wr_sel)) |=> (per == DIV_W'(1) || !tick)) else $error("restart"); // R3

    AST_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && gap_ok && !wr_en && per != DIV_W'(1)) |-> (gap == per)) else $error("period"); // R4

    AST_TICK_ON_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && per != DIV_W'(1)) |-> div_out) else $error("tick level"); // R8

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_en && per != DIV_W'(1)) |=> !tick) else $error("tick width"); // R8

    AST_INV_CLK_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (per == DIV_W'(1)) |-> tick) else $error("div1 tick"); // R6

    AST_HALF_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (per == DIV_W'(2) && !wr_en && $past(rst_n) && !$past(wr_en)) |=> (div_out != $past(div_out)))
        else $error("div2 toggle"); // R7

endmodule

bind baud_divider baud_divider_chk #(.DIV_W(DIV_W), .BYTE_W(BYTE_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .div_out (div_out),
    .tick    (tick)
);

// File: tb/baud_divider_tb.sv
`timescale 1ns/1ps
// Bench for baud_divider: directed corner cases plus seeded random
// divisors, checked against a phase model kept in the bench.
module baud_divider_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic       div_out;
    logic       tick;

    int unsigned n_chk = 0;
    int unsigned n_err = 0;
    logic [7:0]  m_lo = '0;
    logic [7:0]  m_hi = '0;
    int unsigned phase = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    baud_divider u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .div_out(div_out), .tick(tick)
    );

    function automatic int unsigned eff_of(input logic [7:0] hi, input logic [7:0] lo);
        int unsigned v = {hi, lo};
        return (v == 0) ? 3 : v;
    endfunction

    // Expected level of div_out at a rising-edge sample for a phase.
    function automatic logic exp_out(input int unsigned e, input int unsigned ph);
        if (e == 1) return 1'b0;
        if (e == 2) return (ph == 1);
        return (ph >= 2);
    endfunction

    function automatic logic exp_tick(input int unsigned e, input int unsigned ph);
        if (e == 1) return 1'b1;
        if (e == 2) return (ph == 1);
        return (ph == 2);
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%0b exp=%0b div=%0d phase=%0d t=%0t",
                     req, act, exp, eff_of(m_hi, m_lo), phase, $time);
        end
    endtask

    // One clock cycle: drive at the falling edge, sample after the rising edge.
    task automatic cyc(input bit rst, input bit we, input bit sel,
                       input logic [7:0] d, input string req);
        int unsigned e;
        @(negedge clk);
        #1;
        if (rst_n && eff_of(m_hi, m_lo) == 1) check("R6 low-phase", div_out, 1'b1);
        rst_n = !rst; wr_en = we; wr_sel = sel; wr_data = d;
        @(posedge clk);
        #2;
        if (rst) begin
            m_lo = '0; m_hi = '0; phase = 0;
            check("R1 out", div_out, 1'b0);
            check("R1 tick", tick, 1'b0);
        end else begin
            if (we) begin
                if (sel) m_hi = d; else m_lo = d;
                phase = 0;
            end else begin
                e = eff_of(m_hi, m_lo);
                phase = (phase + 1) % e;
            end
            e = eff_of(m_hi, m_lo);
            check(req, div_out, exp_out(e, phase));
            check(req, tick, exp_tick(e, phase));
        end
    endtask

    task automatic idle(input int unsigned n, input string req);
        for (int i = 0; i < int'(n); i++) cyc(1'b0, 1'b0, 1'b0, 8'h00, req);
    endtask

    initial begin : watchdog
        #(200000 * 10);
        n_err++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : stim
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'h5A17);
        // R1: reset, then divide-by-3 from power-up
        for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 1'b0, 8'h00, "R1");
        idle(9, "R1 R5");
        // R4: divisor 5 via low byte (R2)
        cyc(1'b0, 1'b1, 1'b0, 8'd5, "R2 R3");
        idle(12, "R4");
        // R7: divisor 2
        cyc(1'b0, 1'b1, 1'b0, 8'd2, "R3");
        idle(8, "R7 R8");
        // R6: divisor 1
        cyc(1'b0, 1'b1, 1'b0, 8'd1, "R3");
        idle(6, "R6");
        // R5: divisor 0
        cyc(1'b0, 1'b1, 1'b0, 8'd0, "R3");
        idle(7, "R5");
        // R2: high byte, divisor 0x0103 = 259
        cyc(1'b0, 1'b1, 1'b1, 8'h01, "R2");
        cyc(1'b0, 1'b1, 1'b0, 8'h03, "R2 R3");
        idle(270, "R2 R4");
        cyc(1'b0, 1'b1, 1'b1, 8'h00, "R2");
        // R3: rewrite mid-period restarts
        cyc(1'b0, 1'b1, 1'b0, 8'd7, "R3");
        idle(4, "R4");
        cyc(1'b0, 1'b1, 1'b0, 8'd7, "R3 restart");
        idle(10, "R4 R8");
        // R9: write port noise with wr_en low
        for (int i = 0; i < 40; i++)
            cyc(1'b0, 1'b0, 1'($urandom_range(0, 1)), 8'($urandom), "R9");
        // Random divisors
        for (int k = 0; k < 60; k++) begin
            bit use_hi = ($urandom_range(0, 9) == 0);
            cyc(1'b0, 1'b1, 1'b1, use_hi ? 8'h01 : 8'h00, "R2 R3");
            cyc(1'b0, 1'b1, 1'b0, 8'($urandom_range(0, 24)), "R2 R3");
            idle(use_hi ? 300 : 40, "R4 R5 R6 R7 R8");
        end
        // R1: reset clears a programmed divisor
        cyc(1'b0, 1'b1, 1'b0, 8'd9, "R3");
        idle(3, "R4");
        cyc(1'b1, 1'b0, 1'b0, 8'h00, "R1");
        idle(9, "R1 R5");
        cyc(1'b0, 1'b0, 1'b0, 8'h00, "R1");
        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule